// File: doc/BRIEF.md
# Serial EEPROM Command Front End with Write Protection

This block is the serial-slave side of a small byte-addressed EEPROM model. It listens on a four-wire serial link (chip select, serial clock, data in, data out), using clock mode 0. It oversamples the link with its own system clock, turns the bit stream into instruction, address and data bytes, and writes accepted data bytes one at a time into a behavioural memory array through a single-cycle strobe.

Every write has to pass two gates. A write-enable latch must first be set by its own instruction, and it is cleared again when a write or status-write frame closes. A small status register holds a lock bit and a two-bit area guard. The area guard fences off part of the array against data writes. The lock bit, together with the level of the write-protect pin, decides whether the status register can be rewritten at all. Once both the lock bit and a low write-protect pin are present, the guard bits are frozen, and it does not matter which of the two came first. Raising the pin lifts the freeze, and only the area guard remains in force.

Top module: `spiwp_front`

## Requirements
- R1: After reset the status register reads 0x00, the data output enable is low and no memory strobe is issued.
- R2: Instruction 0x06 sets the write-enable latch (status bit 1) and instruction 0x04 clears it.
- R3: Instruction 0x05 returns the status byte MSB first and repeats it for as long as chip select stays low. The status byte carries the lock bit in bit 7, the guard bits in bits 3:2 and the write-enable latch in bit 1; every other bit is 0. The output enable is high only while this status is being sent.
- R4: Instruction 0x02 is followed by a 16-bit address and then data bytes, all MSB first. Each complete data byte produces exactly one `mem_we` pulse carrying that byte and the low ADDR_W address bits. Any address bits above those are ignored.
- R5: Within one write frame the low PAGE_W address bits advance by one after each data byte and wrap inside the page. The bits above them stay fixed.
- R6: When the write-enable latch is clear, a data write or a status write (instruction 0x01) changes neither memory nor status.
- R7: The write-enable latch clears when chip select rises to close an accepted 0x02 frame, or to close a 0x01 frame that carried a complete data byte.
- R8: A 0x01 frame updates the status register only if chip select rises on a byte boundary after at least one full data byte. That byte's bit 7 becomes the lock bit and its bits 3:2 become the guard bits. A frame that ends in the middle of a byte changes nothing, and the latch stays set.
- R9: A status write is accepted when the lock bit is 0, whatever the pin level, and also when the lock bit is 1 and the write-protect pin is high.
- R10: When the lock bit is 1 and the write-protect pin is low at the moment 0x01 is decoded, the status write is rejected. This holds whichever of the two conditions was set first.
- R11: Guard value 00 protects nothing, 01 protects the top quarter of the array, 10 the top half and 11 all of it. A data byte aimed at a protected address produces no strobe.
- R12: The output enable stays low for the whole of a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; a rising edge closes the frame |
| sck | input | 1 | Serial clock; data in is captured on its rising edge |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out, changes after the falling edge of the serial clock |
| so_en | output | 1 | High while `so` is driven; low means high impedance |
| mem_we | output | 1 | One-cycle strobe for a byte write to the array |
| mem_addr | output | ADDR_W | Byte address for the strobe |
| mem_wdata | output | 8 | Data byte for the strobe |

## Verification
The bench builds the block with ADDR_W = 13 and PAGE_W = 3. An 8-byte page means that random burst lengths of up to ten bytes cross the page wrap often, while the quarter and half fences still sit at 0x1800 and 0x1000 of a full 8K space. Random guard values, start addresses, burst lengths and skipped enables are checked strobe by strobe against a bench model of the fence and the page wrap. Directed frames cover the lock bit and the pin being set in both orders, and a status frame aborted mid-byte.

// File: rtl/spiwp_pkg.sv
`timescale 1ns/1ps
package spiwp_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;

    localparam int SR_LOCK_BIT = 7;
    localparam int SR_GUARD_HI = 3;
    localparam int SR_GUARD_LO = 2;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_SR_DATA,
        ST_SR_HOLD,
        ST_STATUS,
        ST_SKIP
    } cmd_state_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] guard;
        logic       wel;
    } status_t;

    function automatic logic [7:0] status_byte(status_t s);
        logic [7:0] b;
        b = '0;
        b[SR_LOCK_BIT] = s.lock;
        b[SR_GUARD_HI:SR_GUARD_LO] = s.guard;
        b[1] = s.wel;
        return b;
    endfunction

    // top2 holds the two most significant bits of the byte address
    function automatic logic area_locked(logic [1:0] guard, logic [1:0] top2);
        logic hit;
        case (guard)
            2'b00:   hit = 1'b0;
            2'b01:   hit = &top2;
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/spiwp_shifter.sv
`timescale 1ns/1ps
module spiwp_shifter
    import spiwp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             si,
    input  logic             tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic             byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic             frame_end,
    output logic             frame_aligned,
    output logic             so
);

    logic                 sck_q;
    logic                 cs_q;
    logic [BYTE_W-2:0]    rx_sr;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    tx_sr;
    logic                 sck_rise;
    logic                 sck_fall;

    assign sck_rise      = sck & ~sck_q & ~cs_n;
    assign sck_fall      = ~sck & sck_q & ~cs_n;
    assign byte_done     = sck_rise && (bit_cnt == BIT_CNT_W'(BYTE_W - 1));
    assign rx_byte       = {rx_sr, si};
    assign frame_end     = cs_n & ~cs_q;
    assign frame_aligned = (bit_cnt == '0);
    assign so            = tx_sr[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sr   <= {rx_sr[BYTE_W-3:0], si};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // The first bit of a loaded byte is presented at once; the falling edge
    // that follows a completed byte must not shift it away.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
        end else if (tx_load) begin
            tx_sr <= tx_byte;
        end else if (sck_fall && (bit_cnt != '0)) begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spiwp_guard.sv
`timescale 1ns/1ps
module spiwp_guard
    import spiwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              sr_arm,
    input  logic              sr_commit,
    input  logic [BYTE_W-1:0] sr_byte,
    input  logic              frame_end,
    output status_t           st
);

    logic permit_q;
    logic hw_lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            permit_q  <= 1'b0;
            hw_lock_q <= 1'b0;
        end else if (sr_arm) begin
            permit_q  <= ~st.lock | wp_n;
            hw_lock_q <= st.lock & ~wp_n;
        end else if (frame_end) begin
            permit_q  <= 1'b0;
            hw_lock_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (sr_commit && permit_q) begin
                st.lock  <= sr_byte[SR_LOCK_BIT];
                st.guard <= sr_byte[SR_GUARD_HI:SR_GUARD_LO];
            end
            if (clr_wel) begin
                st.wel <= 1'b0;
            end else if (set_wel) begin
                st.wel <= 1'b1;
            end
        end
    end

    AST_HW_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hw_lock_q |=> ($stable(st.lock) && $stable(st.guard))); // R10

    AST_SR_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        !($stable(st.lock) && $stable(st.guard)) |-> $past(st.wel)); // R6

endmodule

// File: rtl/spiwp_pager.sv
`timescale 1ns/1ps
module spiwp_pager
    import spiwp_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic              step,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr
);

    localparam int HI_W = ADDR_W - BYTE_W;

    generate
        if (HI_W < BYTE_W) begin : g_drop
            logic unused_hi;
            assign unused_hi = ^byte_in[BYTE_W-1:HI_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load_hi) begin
            addr[ADDR_W-1:BYTE_W] <= byte_in[HI_W-1:0];
        end else if (load_lo) begin
            addr[BYTE_W-1:0] <= byte_in;
        end else if (step) begin
            addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
        end
    end

    AST_PAGE_HIGH_FIXED: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(addr[ADDR_W-1:PAGE_W])); // R5

endmodule

// File: rtl/spiwp_front.sv
`timescale 1ns/1ps
module spiwp_front
    import spiwp_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              wp_n,
    output logic              so,
    output logic              so_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata
);

    cmd_state_e        state, nxt;
    status_t           st;
    logic              byte_done, frame_end, frame_aligned;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load;
    logic              set_wel, clr_wel, sr_arm, sr_commit;
    logic              ld_hi, ld_lo, step, we_fire, cap_sr, arm_wr;
    logic              wr_armed_q;
    logic [BYTE_W-1:0] sr_byte_q;
    logic [ADDR_W-1:0] cur_addr;

    spiwp_shifter u_shift (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .tx_load(tx_load), .tx_byte(status_byte(st)),
        .byte_done(byte_done), .rx_byte(rx_byte),
        .frame_end(frame_end), .frame_aligned(frame_aligned), .so(so)
    );

    spiwp_guard u_guard (
        .clk(clk), .rst(rst), .wp_n(wp_n),
        .set_wel(set_wel), .clr_wel(clr_wel),
        .sr_arm(sr_arm), .sr_commit(sr_commit), .sr_byte(sr_byte_q),
        .frame_end(frame_end), .st(st)
    );

    spiwp_pager #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_pager (
        .clk(clk), .rst(rst), .load_hi(ld_hi), .load_lo(ld_lo),
        .step(step), .byte_in(rx_byte), .addr(cur_addr)
    );

    always_comb begin
        nxt       = state;
        set_wel   = 1'b0;
        clr_wel   = 1'b0;
        sr_arm    = 1'b0;
        sr_commit = 1'b0;
        tx_load   = 1'b0;
        ld_hi     = 1'b0;
        ld_lo     = 1'b0;
        step      = 1'b0;
        we_fire   = 1'b0;
        cap_sr    = 1'b0;
        arm_wr    = 1'b0;
        if (frame_end) begin
            nxt = ST_OPCODE;
            if (state == ST_SR_HOLD && frame_aligned) begin
                sr_commit = 1'b1;
                clr_wel   = 1'b1;
            end
            if (wr_armed_q) begin
                clr_wel = 1'b1;
            end
        end else if (byte_done) begin
            case (state)
                ST_OPCODE: begin
                    nxt = ST_SKIP;
                    case (rx_byte)
                        OP_WREN: set_wel = 1'b1;
                        OP_WRDI: clr_wel = 1'b1;
                        OP_RDSR: begin
                            tx_load = 1'b1;
                            nxt     = ST_STATUS;
                        end
                        OP_WRSR: if (st.wel) begin
                            sr_arm = 1'b1;
                            nxt    = ST_SR_DATA;
                        end
                        OP_WRITE: if (st.wel) begin
                            arm_wr = 1'b1;
                            nxt    = ST_ADDR_HI;
                        end
                        default: nxt = ST_SKIP;
                    endcase
                end
                ST_ADDR_HI: begin
                    ld_hi = 1'b1;
                    nxt   = ST_ADDR_LO;
                end
                ST_ADDR_LO: begin
                    ld_lo = 1'b1;
                    nxt   = ST_DATA;
                end
                ST_DATA: begin
                    we_fire = !area_locked(st.guard, cur_addr[ADDR_W-1:ADDR_W-2]);
                    step    = 1'b1;
                end
                ST_SR_DATA: begin
                    cap_sr = 1'b1;
                    nxt    = ST_SR_HOLD;
                end
                ST_STATUS: tx_load = 1'b1;
                default: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OPCODE;
            wr_armed_q <= 1'b0;
            sr_byte_q  <= '0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
        end else begin
            state  <= nxt;
            mem_we <= we_fire;
            if (we_fire) begin
                mem_addr  <= cur_addr;
                mem_wdata <= rx_byte;
            end
            if (cap_sr) begin
                sr_byte_q <= rx_byte;
            end
            if (arm_wr) begin
                wr_armed_q <= 1'b1;
            end else if (frame_end) begin
                wr_armed_q <= 1'b0;
            end
        end
    end

    assign so_en = ~cs_n && (state == ST_STATUS);

    AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> st.wel); // R6

    AST_WE_OPEN_AREA: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !area_locked(st.guard, mem_addr[ADDR_W-1:ADDR_W-2])); // R11

    AST_SO_QUIET_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !so_en); // R12

endmodule

// File: tb/sim_spiwp_front.sv
`timescale 1ns/1ps
module sim_spiwp_front;

    localparam int AW   = 13;
    localparam int PW   = 3;
    localparam int HALF = 4;
    localparam int LOGN = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          si = 1'b0;
    logic          wp_n = 1'b1;
    logic          so, so_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [AW-1:0] log_a [LOGN];
    logic [7:0]    log_d [LOGN];
    int            log_n = 0;
    logic [AW-1:0] exp_a [LOGN];
    logic [7:0]    exp_d [LOGN];
    int            exp_n = 0;
    logic [7:0]    pw_data [16];

    always #2.5 clk = ~clk;

    spiwp_front #(.ADDR_W(AW), .PAGE_W(PW)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
        .so(so), .so_en(so_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(negedge clk) begin
        if (mem_we && log_n < LOGN) begin
            log_a[log_n] = mem_addr;
            log_d[log_n] = mem_wdata;
            log_n = log_n + 1;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic prot(input logic [AW-1:0] a, input logic [1:0] g);
        case (g)
            2'd0: return 1'b0;
            2'd1: return a >= AW'(3 * (1 << (AW - 2)));
            2'd2: return a >= AW'(1 << (AW - 1));
            default: return 1'b1;
        endcase
    endfunction

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            si = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = so;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        xfer(b, r);
    endtask

    task automatic open_f();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic close_f();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        open_f(); send(op); close_f();
    endtask

    task automatic read_sr(output logic [7:0] s);
        open_f(); send(8'h05); xfer(8'h00, s); close_f();
    endtask

    task automatic sr_write(input logic [7:0] v);
        cmd1(8'h06);
        open_f(); send(8'h01); send(v); close_f();
    endtask

    task automatic page_write(input logic [15:0] a16, input int n, output logic oe_seen);
        open_f();
        send(8'h02); send(a16[15:8]); send(a16[7:0]);
        oe_seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            send(pw_data[k]);
            oe_seen = oe_seen | so_en;
        end
        close_f();
    endtask

    task automatic build_exp(input logic [15:0] a16, input int n, input logic [1:0] g, input logic en);
        exp_n = 0;
        if (en) begin
            for (int k = 0; k < n; k++) begin
                logic [AW-1:0] a;
                a = a16[AW-1:0];
                a[PW-1:0] = a16[PW-1:0] + PW'(k);
                if (!prot(a, g)) begin
                    exp_a[exp_n] = a;
                    exp_d[exp_n] = pw_data[k];
                    exp_n = exp_n + 1;
                end
            end
        end
    endtask

    task automatic cmp_log(input string req);
        chk({req, " strobe count"}, 32'(log_n), 32'(exp_n));
        for (int k = 0; k < exp_n && k < log_n; k++) begin
            chk({req, " addr"}, 32'(log_a[k]), 32'(exp_a[k]));
            chk({req, " data"}, 32'(log_d[k]), 32'(exp_d[k]));
        end
    endtask

    initial begin
        logic [7:0] s, s2;
        logic       oe;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 so_en idle", 32'(so_en), 0);
        chk("R1 mem_we idle", 32'(mem_we), 0);
        read_sr(s);
        chk("R1 status after reset", 32'(s), 32'h00);

        // R2 latch set and clear
        cmd1(8'h06); read_sr(s);
        chk("R2 enable sets bit 1", 32'(s), 32'h02);
        cmd1(8'h04); read_sr(s);
        chk("R2 disable clears bit 1", 32'(s), 32'h00);

        // R3 repeated status output with driver enabled
        cmd1(8'h06);
        open_f(); send(8'h05); xfer(8'h00, s);
        chk("R3 so_en during status", 32'(so_en), 1);
        xfer(8'h00, s2); close_f();
        chk("R3 status first byte", 32'(s), 32'h02);
        chk("R3 status repeats", 32'(s2), 32'(s));
        chk("R3 so_en after frame", 32'(so_en), 0);
        cmd1(8'h04);

        // R6 write without latch
        log_n = 0; pw_data[0] = 8'h3C;
        page_write(16'h0010, 1, oe);
        chk("R6 no strobe without latch", 32'(log_n), 0);

        // R4 upper address bits ignored, R7 latch cleared, R12 driver off
        cmd1(8'h06); log_n = 0; pw_data[0] = 8'hA5;
        page_write(16'hE005, 1, oe);
        build_exp(16'hE005, 1, 2'd0, 1'b1); cmp_log("R4");
        chk("R12 so_en during write", 32'(oe), 0);
        read_sr(s);
        chk("R7 latch cleared after write", 32'(s), 32'h00);

        // R5 page wrap
        cmd1(8'h06); log_n = 0;
        for (int k = 0; k < 4; k++) pw_data[k] = 8'(8'h50 + k);
        page_write(16'h0106, 4, oe);
        build_exp(16'h0106, 4, 2'd0, 1'b1); cmp_log("R5");
        chk("R5 wrapped address", 32'(log_a[2]), 32'h0100);

        // R6 status write without latch
        open_f(); send(8'h01); send(8'h8C); close_f(); read_sr(s);
        chk("R6 status write ignored", 32'(s), 32'h00);

        // R9 lock clear: accepted even with pin low; R7 latch clears
        wp_n = 1'b0; sr_write(8'h8C); read_sr(s);
        chk("R9 accepted with lock 0 pin low", 32'(s), 32'h8C);
        chk("R7 latch cleared after status write", 32'(s[1]), 0);

        // R9 lock 1 pin high accepted
        wp_n = 1'b1; sr_write(8'h88); read_sr(s);
        chk("R9 accepted with lock 1 pin high", 32'(s), 32'h88);

        // R10 lock first then pin low
        wp_n = 1'b0; sr_write(8'h00); read_sr(s);
        chk("R10 rejected lock then pin", 32'(s), 32'h88);

        // R10 pin low first then lock
        wp_n = 1'b1; sr_write(8'h00);
        wp_n = 1'b0; sr_write(8'h84); read_sr(s);
        chk("R10 lock set while pin low", 32'(s), 32'h84);
        sr_write(8'h00); read_sr(s);
        chk("R10 rejected pin then lock", 32'(s), 32'h84);

        // R8 mid-byte abort
        wp_n = 1'b1; cmd1(8'h06);
        open_f(); send(8'h01);
        for (int i = 0; i < 4; i++) begin
            si = 1'b0;
            repeat (HALF) @(negedge clk); sck = 1'b1;
            repeat (HALF) @(negedge clk); sck = 1'b0;
        end
        close_f(); read_sr(s);
        chk("R8 aborted status write", 32'(s), 32'h86);
        open_f(); send(8'h01); send(8'h00); close_f(); read_sr(s);
        chk("R8 aligned status write", 32'(s), 32'h00);

        // R11 directed quarter fence
        sr_write(8'h04);
        cmd1(8'h06); log_n = 0; pw_data[0] = 8'h11;
        page_write(16'h17FF, 1, oe);
        chk("R11 below quarter written", 32'(log_n), 1);
        cmd1(8'h06); log_n = 0;
        page_write(16'h1800, 1, oe);
        chk("R11 top quarter discarded", 32'(log_n), 0);

        // R11 R5 R6 random bursts
        for (int it = 0; it < 30; it++) begin
            logic [1:0]  g;
            logic [15:0] a16;
            logic        en;
            int          n;
            g   = 2'($urandom % 4);
            en  = ($urandom % 5) != 0;
            a16 = 16'($urandom);
            n   = 1 + int'($urandom % 10);
            if (it < 4) a16[AW-1:AW-2] = 2'(it);
            for (int k = 0; k < n; k++) pw_data[k] = 8'($urandom);
            sr_write({4'b0, g, 2'b00});
            if (en) cmd1(8'h06);
            log_n = 0;
            page_write(a16, n, oe);
            build_exp(a16, n, g, en);
            cmp_log("R11 random burst");
            chk("R12 so_en random burst", 32'(oe), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule